// File: doc/BRIEF.md
# Boot-window command sequencer

This block sits behind the boot-window part of a memory-mapped flash device. It watches host writes and decodes the small command set that this window accepts. A single write can ask for a warm reset or for the identification data. A page load takes two writes: an arming write, then a confirming write. When the confirming write arrives, the block turns the current block and page start-address words into a flat sector number. It then issues a one-cycle load request for one full page, which is four 512-byte sectors.

The block holds the page start-address word. The host can overwrite that word through a dedicated load port, and every page load advances it by one page. The block start-address word comes from a neighbouring register. When bit 15 of that word is set, the sector calculation ORs in a density mask, which is fixed per device as a parameter. The block does not move any data. It only produces requests.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write of 0x00F0 inside the boot window, while not armed, gives a one-cycle `rst_req` pulse in the cycle after the write.
- R2: A write of 0x0090 inside the boot window, while not armed, gives a one-cycle `id_req` pulse in the cycle after the write.
- R3: A write of 0x00E0 inside the boot window arms the sequencer. If the next boot-window write has the value 0x0000, `load_req` pulses for one cycle in the cycle after that write, and `load_cnt` reads 4.
- R4: The sector number on `load_sector` is `(field << 8) | page[7:0]`, computed from the page word before the load. Here `field` is bits 11:0 of `blk_word`.
- R5: In the cycle after a page load, `pg_word` equals the old `pg_word` plus 4, kept to 8 bits, with bits 15:8 zero. The value wraps from 0xFC to 0x00.
- R6: When bit 15 of `blk_word` is set, `field` is ORed with `DENSITY_MASK` before it is used in the sector number.
- R7: While armed, the next boot-window write always disarms the sequencer. If its value is not 0x0000, no request and no warning is issued.
- R8: Only word offsets 0x0000 to 0x01FF and 0x8000 to 0x800F belong to the boot window. Writes at other offsets issue nothing and leave the armed state unchanged.
- R9: Any other value written inside the boot window while not armed gives a one-cycle `unk_cmd` pulse and no request.
- R10: `pg_ld` loads `pg_ld_val` into `pg_word` on the next edge. If a page load happens in the same cycle, `pg_ld` wins.
- R11: After reset, all pulses are low, `pg_word` is 0 and the sequencer is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Word offset of the write |
| wr_data | input | 16 | Written value |
| blk_word | input | 16 | Block start-address word |
| pg_ld | input | 1 | Load strobe for the page word |
| pg_ld_val | input | 16 | Value for the page word |
| pg_word | output | 16 | Page start-address word |
| load_req | output | 1 | Page load request pulse |
| load_sector | output | BLK_W+8 | Flat sector number of the load |
| load_cnt | output | 3 | Sectors per load (always 4) |
| id_req | output | 1 | Identification request pulse |
| rst_req | output | 1 | Warm reset request pulse |
| unk_cmd | output | 1 | Unknown boot command warning pulse |

## Verification
The bench builds the block with a 12-bit block field and a density mask of 0x200. With these values, the high-block OR can be seen directly in the upper sector bits, and it can be told apart from the low block field. The page word is preset to values near 0xFF, which lets the 8-bit wrap of the auto-advance be reached after a single load. Writes at each edge of both window ranges, and one step past each edge, cover the window decode.

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq #(
  parameter int BLK_W = 12,
  parameter logic [BLK_W-1:0] DENSITY_MASK = 12'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [15:0]      blk_word,
  input  logic             pg_ld,
  input  logic [15:0]      pg_ld_val,
  output logic [15:0]      pg_word,
  output logic             load_req,
  output logic [BLK_W+7:0] load_sector,
  output logic [2:0]       load_cnt,
  output logic             id_req,
  output logic             rst_req,
  output logic             unk_cmd
);
  localparam int SEC_W = BLK_W + 8;

  logic armed;
  logic in_win, boot_wr, fire_load;
  logic [BLK_W-1:0] field;

  assign in_win    = (wr_addr[15:9] == 7'h00) || (wr_addr[15:4] == 12'h800);
  assign boot_wr   = wr_en && in_win;
  assign fire_load = boot_wr && armed && (wr_data == 16'h0000);
  assign field     = blk_word[BLK_W-1:0] | (blk_word[15] ? DENSITY_MASK : '0);
  assign load_cnt  = 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      load_req    <= 1'b0;
      id_req      <= 1'b0;
      rst_req     <= 1'b0;
      unk_cmd     <= 1'b0;
      load_sector <= '0;
    end else begin
      load_req <= 1'b0;
      id_req   <= 1'b0;
      rst_req  <= 1'b0;
      unk_cmd  <= 1'b0;
      if (boot_wr) begin
        if (armed) begin
          armed <= 1'b0;
          if (fire_load) begin
            load_req    <= 1'b1;
            load_sector <= SEC_W'({field, pg_word[7:0]});
          end
        end else begin
          case (wr_data)
            16'h00F0: rst_req <= 1'b1;
            16'h0090: id_req  <= 1'b1;
            16'h00E0: armed   <= 1'b1;
            default:  unk_cmd <= 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pg_word <= '0;
    else if (pg_ld)     pg_word <= pg_ld_val;
    else if (fire_load) pg_word <= {8'h00, pg_word[7:0] + 8'd4};
  end

  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_req, id_req, rst_req, unk_cmd}));

  assert_load_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  assert_page_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !$past(pg_ld)) |-> (pg_word == {8'h00, $past(pg_word[7:0]) + 8'd4}));

  assert_reset_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wr_en) && $past(wr_data) == 16'h00F0));

  assert_armed_after_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && boot_wr && wr_data == 16'h00E0) |=> armed);

  assert_outside_keeps_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_wr && !$past(!rst_n)) |=> $stable(armed));
endmodule

// File: tb/tb_boot_cmd_seq.sv
module tb_boot_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, blk_word = '0, pg_ld_val = '0;
  logic        pg_ld = 1'b0;
  logic [15:0] pg_word;
  logic        load_req, id_req, rst_req, unk_cmd;
  logic [19:0] load_sector;
  logic [2:0]  load_cnt;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cmd_seq #(.BLK_W(12), .DENSITY_MASK(12'h200)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_word(blk_word), .pg_ld(pg_ld), .pg_ld_val(pg_ld_val), .pg_word(pg_word),
    .load_req(load_req), .load_sector(load_sector), .load_cnt(load_cnt),
    .id_req(id_req), .rst_req(rst_req), .unk_cmd(unk_cmd));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pulses();
    return {load_req, id_req, rst_req, unk_cmd};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_pg(input logic [15:0] v);
    @(negedge clk); pg_ld = 1'b1; pg_ld_val = v;
    @(negedge clk); pg_ld = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R11 pulses", 32'(pulses()), 0);
    chk("R11 pg_word", 32'(pg_word), 0);
  endtask

  task automatic t_warm_reset();
    wr(16'h0010, 16'h00F0);
    chk("R1 rst_req", 32'(pulses()), 32'b0010);
    @(negedge clk);
    chk("R1 one cycle", 32'(pulses()), 0);
  endtask

  task automatic t_ident();
    wr(16'h8005, 16'h0090);
    chk("R2 id_req", 32'(pulses()), 32'b0100);
    @(negedge clk);
    chk("R2 one cycle", 32'(pulses()), 0);
  endtask

  task automatic t_load_basic();
    set_pg(16'h0025);
    chk("R10 pg load", 32'(pg_word), 32'h25);
    blk_word = 16'h0003;
    wr(16'h0000, 16'h00E0);
    chk("R3 armed no pulse", 32'(pulses()), 0);
    wr(16'h0100, 16'h0000);
    chk("R3 load_req", 32'(pulses()), 32'b1000);
    chk("R3 load_cnt", 32'(load_cnt), 4);
    chk("R4 sector", 32'(load_sector), 32'h00325);
    chk("R5 advance", 32'(pg_word), 32'h29);
    @(negedge clk);
    chk("R3 one cycle", 32'(pulses()), 0);
  endtask

  task automatic t_wrap_and_density();
    set_pg(16'h12FE);
    blk_word = 16'h8005;
    wr(16'h01FF, 16'h00E0);
    wr(16'h800F, 16'h0000);
    chk("R6 sector", 32'(load_sector), 32'h205FE);
    chk("R5 wrap", 32'(pg_word), 32'h0002);
    blk_word = 16'h0005;
    wr(16'h8000, 16'h00E0);
    wr(16'h8000, 16'h0000);
    chk("R6 no mask", 32'(load_sector), 32'h00502);
  endtask

  task automatic t_cancel();
    set_pg(16'h0040);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0090);
    chk("R7 no pulse", 32'(pulses()), 0);
    chk("R7 pg kept", 32'(pg_word), 32'h40);
    wr(16'h0000, 16'h0000);
    chk("R7 disarmed", 32'(pulses()), 32'b0001);
    chk("R7 pg still", 32'(pg_word), 32'h40);
  endtask

  task automatic t_window();
    wr(16'h0200, 16'h0090);
    chk("R8 above low range", 32'(pulses()), 0);
    wr(16'h8010, 16'h0090);
    chk("R8 above high range", 32'(pulses()), 0);
    wr(16'h7FFF, 16'h00F0);
    chk("R8 below high range", 32'(pulses()), 0);
    wr(16'h01FF, 16'h0090);
    chk("R8 low edge", 32'(pulses()), 32'b0100);
    set_pg(16'h0010);
    blk_word = 16'h0001;
    wr(16'h0000, 16'h00E0);
    wr(16'h4000, 16'h0000);
    chk("R8 outside no load", 32'(pulses()), 0);
    wr(16'h800F, 16'h0000);
    chk("R8 still armed", 32'(pulses()), 32'b1000);
    chk("R4 sector", 32'(load_sector), 32'h00110);
  endtask

  task automatic t_unknown();
    wr(16'h0044, 16'h1234);
    chk("R9 unk_cmd", 32'(pulses()), 32'b0001);
    @(negedge clk);
    chk("R9 one cycle", 32'(pulses()), 0);
  endtask

  task automatic t_ld_priority();
    set_pg(16'h0080);
    wr(16'h0000, 16'h00E0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 16'h0000; wr_data = 16'h0000;
    pg_ld = 1'b1; pg_ld_val = 16'h0033;
    @(negedge clk); wr_en = 1'b0; pg_ld = 1'b0;
    chk("R10 priority", 32'(pg_word), 32'h33);
    chk("R10 load still fired", 32'(pulses()), 32'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_warm_reset();
    t_ident();
    t_load_basic();
    t_wrap_and_density();
    t_cancel();
    t_window();
    t_unknown();
    t_ld_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule